// File: doc/BRIEF.md
# Scanline IRQ bank controller

This block holds the bank-switching state of a cartridge-style memory controller and counts video scanlines to raise an interrupt. The CPU writes to it through eight register slots. Each slot is picked by address bits A15..A13 and A0. The block keeps eight bank registers, an index/mode byte, a mirroring bit, a RAM control byte and an interrupt counter. It presents the registers along with the derived window assignments: eight 1 KiB character slots and four 8 KiB program windows. It also drives a level interrupt output.

The video side supplies a single-cycle `scanline` strobe once per line. When the counter is zero, a strobe reloads it from the latched reload value. Otherwise a strobe decrements it. If the new value is zero and interrupts are enabled, the interrupt is raised. The interrupt stays high until software acknowledges it. The following are left to neighbouring logic: producing the scanline strobe from video address activity, the final address multiplexing and any outer bank masking.

Top module: `scanirq_bank_ctrl`

## Requirements
- R1: A write takes effect only when `wr_en` is high and A15 (`wr_addr_hi[2]`) is 1. The slot number is {A14, A13, A0}. A write with A15 = 0 changes no output.
- R2: Slot 0 stores the index/mode byte on `index_reg`. Its bit 6 drives `prg_swap` and its bit 7 drives `chr_swap`.
- R3: Slot 1 stores the data byte into bank register number index[2:0]. Bank register k appears on `bank_regs[8k+7:8k]`.
- R4: Slot 2 stores the mirroring bit, and `mirror` equals the inverse of bit 0 of the last byte written there. Slot 3 stores the RAM control byte on `ram_ctrl`.
- R5: Slot 4 latches the reload value. Slot 5 clears the counter to zero, so the next scanline strobe reloads it.
- R6: On a scanline strobe, a counter at zero is reloaded and any other value is decremented. If the result is zero and interrupts are enabled, `irq` rises at that clock edge. With a reload value of zero, every strobe gives a zero result.
- R7: Slot 6 disables interrupts and drops `irq` at that edge. Slot 7 enables interrupts. Once raised, `irq` stays high through further scanlines until a slot 6 write.
- R8: Unswapped character slots s = 0..3 carry bank register s/2 with bit 0 replaced by s mod 2. Slots 4..7 carry bank registers 2..5. When `chr_swap` is 1, slot s shows the unswapped value of slot s XOR 4. Slot s occupies `chr_bank[8s+7:8s]`.
- R9: Unswapped program windows 0..3 carry bank register 6, bank register 7, 0xFE and 0xFF. When `prg_swap` is 1, windows 0 and 2 exchange their contents. Window w occupies `prg_bank[8w+7:8w]`.
- R10: A slot 5 write in the same cycle as a scanline strobe leaves the counter at zero and raises no interrupt. A slot 6 write in the same cycle as a firing strobe leaves `irq` low. A strobe in the same cycle as a slot 4 or slot 7 write uses the old reload value or the old enable.
- R11: Reset clears every register, the counter and the enable. After reset `irq` is 0 and `mirror` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr_hi | input | 3 | Address bits A15, A14, A13 (bit 2 = A15) |
| wr_a0 | input | 1 | Address bit A0 |
| wr_data | input | 8 | Write data byte |
| scanline | input | 1 | One-cycle strobe per video line |
| bank_regs | output | 64 | Eight bank registers, register k in byte k |
| index_reg | output | 8 | Index/mode byte |
| prg_swap | output | 1 | Program window swap (index bit 6) |
| chr_swap | output | 1 | Character half swap (index bit 7) |
| mirror | output | 1 | Mirroring select |
| ram_ctrl | output | 8 | RAM control byte |
| chr_bank | output | 64 | Bank numbers for the eight 1 KiB character slots |
| prg_bank | output | 32 | Bank numbers for the four 8 KiB program windows |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the counter's zero-then-reload rule. A design that decrements through zero, or that reloads on the wrong strobe, would fire one line early or late. A reload value of zero has to fire on every line, or a design would hang silent. The same-cycle collisions of clear, acknowledge and enable with a strobe are driven on purpose, because a wrong priority shows up as a spurious or missing interrupt. Writes with A15 low, both swap bits and the bit 0 forcing on the 2 KiB character pairs are exercised as well. A swapped half or a pair without its forced bit would put the wrong bank on a character slot.

// File: rtl/sibc_pkg.sv
package sibc_pkg;

   localparam int SIBC_NBANK = 8;
   localparam int SIBC_NSLOT = 8;
   localparam int SIBC_NCHR  = 8;
   localparam int SIBC_NPRG  = 4;
   localparam int SIBC_IDX_W = $clog2(SIBC_NBANK);

   typedef enum logic [2:0] {
      SLOT_INDEX  = 3'd0,
      SLOT_BANK   = 3'd1,
      SLOT_MIRR   = 3'd2,
      SLOT_RAM    = 3'd3,
      SLOT_RELOAD = 3'd4,
      SLOT_CLEAR  = 3'd5,
      SLOT_IRQOFF = 3'd6,
      SLOT_IRQON  = 3'd7
   } slot_e;

endpackage

// File: rtl/sibc_decode.sv
module sibc_decode
   import sibc_pkg::*;
(
   input  logic                  wr_en,
   input  logic [2:0]            wr_addr_hi,
   input  logic                  wr_a0,
   output logic [SIBC_NSLOT-1:0] slot_stb
);

   logic [2:0] slot_num;

   assign slot_num = {wr_addr_hi[1:0], wr_a0};

   always_comb begin
      slot_stb = '0;
      if (wr_en && wr_addr_hi[2]) begin
         slot_stb[slot_num] = 1'b1;
      end
   end

endmodule

// File: rtl/sibc_regfile.sv
module sibc_regfile
   import sibc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SIBC_NSLOT-1:0]        slot_stb,
   input  logic [DATA_W-1:0]            wr_data,
   output logic [SIBC_NBANK*DATA_W-1:0] bank_flat,
   output logic [DATA_W-1:0]            index_q,
   output logic                         mirr_q,
   output logic [DATA_W-1:0]            ram_q
);

   localparam int SEL_W = SIBC_IDX_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         mirr_q  <= 1'b0;
         ram_q   <= '0;
      end else begin
         if (slot_stb[SLOT_INDEX]) index_q <= wr_data;
         if (slot_stb[SLOT_MIRR])  mirr_q  <= wr_data[0];
         if (slot_stb[SLOT_RAM])   ram_q   <= wr_data;
      end
   end

   for (genvar g = 0; g < SIBC_NBANK; g++) begin : g_bank
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (slot_stb[SLOT_BANK] && (index_q[SEL_W-1:0] == SEL_W'(g))) begin
            q <= wr_data;
         end
      end
      assign bank_flat[g*DATA_W +: DATA_W] = q;
   end

   // R2: index byte lands on the next edge
   a_r2_index_store: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb[SLOT_INDEX] |=> index_q == $past(wr_data));

   // R3: the addressed bank register takes the data
   a_r3_bank_store: assert property (@(posedge clk) disable iff (!rst_n)
      slot_stb[SLOT_BANK] |=>
         bank_flat[$past(index_q[SEL_W-1:0])*DATA_W +: DATA_W] == $past(wr_data));

endmodule

// File: rtl/sibc_irq.sv
module sibc_irq #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scanline,
   input  logic             reload_stb,
   input  logic             clear_stb,
   input  logic             off_stb,
   input  logic             on_stb,
   input  logic [CNT_W-1:0] wr_val,
   output logic             irq
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             en_q;
   logic             irq_q;
   logic             fire;

   always_comb begin
      cnt_nxt = (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
      fire    = scanline && !clear_stb && (cnt_nxt == '0) && en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
         en_q     <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (reload_stb) reload_q <= wr_val;

         if (clear_stb)     cnt_q <= '0;
         else if (scanline) cnt_q <= cnt_nxt;

         if (off_stb)     en_q <= 1'b0;
         else if (on_stb) en_q <= 1'b1;

         if (off_stb)   irq_q <= 1'b0;
         else if (fire) irq_q <= 1'b1;
      end
   end

   assign irq = irq_q;

   // R7: acknowledge drops the request
   a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      off_stb |=> !irq);

   // R7: a raised request is held until acknowledged
   a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !off_stb) |=> irq);

   // R10: clear wins over a coincident scanline
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clear_stb |=> cnt_q == '0);

   // R6: zero counter reloads from the latched value
   a_r6_reload_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (scanline && !clear_stb && cnt_q == '0) |=> cnt_q == $past(reload_q));

   // R6: non-zero counter steps down by one
   a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (scanline && !clear_stb && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/sibc_window_map.sv
module sibc_window_map
   import sibc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [SIBC_NBANK*DATA_W-1:0] bank_flat,
   input  logic                         chr_swap,
   input  logic                         prg_swap,
   output logic [SIBC_NCHR*DATA_W-1:0]  chr_flat,
   output logic [SIBC_NPRG*DATA_W-1:0]  prg_flat
);

   localparam int                HALF    = SIBC_NCHR / 2;
   localparam logic [DATA_W-1:0] FIX_TOP = '1;
   localparam logic [DATA_W-1:0] FIX_LOW = {{(DATA_W-1){1'b1}}, 1'b0};

   logic [DATA_W-1:0] bank [SIBC_NBANK];
   logic [DATA_W-1:0] chr_base [SIBC_NCHR];

   for (genvar b = 0; b < SIBC_NBANK; b++) begin : g_unpack
      assign bank[b] = bank_flat[b*DATA_W +: DATA_W];
   end

   for (genvar s = 0; s < SIBC_NCHR; s++) begin : g_chr
      if (s < HALF) begin : g_pair
         assign chr_base[s] = {bank[s/2][DATA_W-1:1], 1'(s % 2)};
      end else begin : g_single
         assign chr_base[s] = bank[s-2];
      end
      assign chr_flat[s*DATA_W +: DATA_W] = chr_swap ? chr_base[s ^ HALF] : chr_base[s];
   end

   assign prg_flat[0*DATA_W +: DATA_W] = prg_swap ? FIX_LOW : bank[6];
   assign prg_flat[1*DATA_W +: DATA_W] = bank[7];
   assign prg_flat[2*DATA_W +: DATA_W] = prg_swap ? bank[6] : FIX_LOW;
   assign prg_flat[3*DATA_W +: DATA_W] = FIX_TOP;

endmodule

// File: rtl/scanirq_bank_ctrl.sv
module scanirq_bank_ctrl
   import sibc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [2:0]                   wr_addr_hi,
   input  logic                         wr_a0,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         scanline,
   output logic [SIBC_NBANK*DATA_W-1:0] bank_regs,
   output logic [DATA_W-1:0]            index_reg,
   output logic                         prg_swap,
   output logic                         chr_swap,
   output logic                         mirror,
   output logic [DATA_W-1:0]            ram_ctrl,
   output logic [SIBC_NCHR*DATA_W-1:0]  chr_bank,
   output logic [SIBC_NPRG*DATA_W-1:0]  prg_bank,
   output logic                         irq
);

   localparam int PRG_SWAP_BIT = 6;
   localparam int CHR_SWAP_BIT = 7;

   if (DATA_W < 8) begin : g_bad_data_w
      $error("scanirq_bank_ctrl: DATA_W must be at least 8");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("scanirq_bank_ctrl: CNT_W must lie in 1..DATA_W");
   end

   logic [SIBC_NSLOT-1:0] slot_stb;
   logic                  mirr_q;

   sibc_decode u_decode (
      .wr_en      (wr_en),
      .wr_addr_hi (wr_addr_hi),
      .wr_a0      (wr_a0),
      .slot_stb   (slot_stb)
   );

   sibc_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_stb  (slot_stb),
      .wr_data   (wr_data),
      .bank_flat (bank_regs),
      .index_q   (index_reg),
      .mirr_q    (mirr_q),
      .ram_q     (ram_ctrl)
   );

   sibc_irq #(.CNT_W(CNT_W)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .scanline   (scanline),
      .reload_stb (slot_stb[SLOT_RELOAD]),
      .clear_stb  (slot_stb[SLOT_CLEAR]),
      .off_stb    (slot_stb[SLOT_IRQOFF]),
      .on_stb     (slot_stb[SLOT_IRQON]),
      .wr_val     (wr_data[CNT_W-1:0]),
      .irq        (irq)
   );

   assign prg_swap = index_reg[PRG_SWAP_BIT];
   assign chr_swap = index_reg[CHR_SWAP_BIT];
   assign mirror   = ~mirr_q;

   sibc_window_map #(.DATA_W(DATA_W)) u_map (
      .bank_flat (bank_regs),
      .chr_swap  (chr_swap),
      .prg_swap  (prg_swap),
      .chr_flat  (chr_bank),
      .prg_flat  (prg_bank)
   );

endmodule

// File: tb/scanirq_bank_ctrl_tb_top.sv
module scanirq_bank_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr_hi = 3'd0;
   logic        wr_a0 = 1'b0;
   logic [7:0]  wr_data = 8'd0;
   logic        scanline = 1'b0;
   logic [63:0] bank_regs;
   logic [7:0]  index_reg;
   logic        prg_swap;
   logic        chr_swap;
   logic        mirror;
   logic [7:0]  ram_ctrl;
   logic [63:0] chr_bank;
   logic [31:0] prg_bank;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference state
   int m_bank [8];
   int m_idx, m_mirr, m_ram, m_reload, m_cnt, m_en, m_irq;

   always #10 clk = ~clk;

   scanirq_bank_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr_hi(wr_addr_hi),
      .wr_a0(wr_a0), .wr_data(wr_data), .scanline(scanline),
      .bank_regs(bank_regs), .index_reg(index_reg), .prg_swap(prg_swap),
      .chr_swap(chr_swap), .mirror(mirror), .ram_ctrl(ram_ctrl),
      .chr_bank(chr_bank), .prg_bank(prg_bank), .irq(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_bank[i]) m_bank[i] = 0;
         m_idx = 0; m_mirr = 0; m_ram = 0; m_reload = 0;
         m_cnt = 0; m_en = 0; m_irq = 0;
      end else begin
         int slot, nxt, old_en, old_reload;
         slot = (wr_en && wr_addr_hi[2]) ? {wr_addr_hi[1:0], wr_a0} : -1;
         old_en = m_en;
         old_reload = m_reload;
         nxt = (m_cnt == 0) ? old_reload : ((m_cnt - 1) & 255);
         case (slot)
            0: m_idx = wr_data;
            1: m_bank[m_idx & 7] = wr_data;
            2: m_mirr = wr_data & 1;
            3: m_ram = wr_data;
            4: m_reload = wr_data;
            6: m_en = 0;
            7: m_en = 1;
            default: ;
         endcase
         if (slot == 5) m_cnt = 0;
         else if (scanline) m_cnt = nxt;
         if (slot == 6) m_irq = 0;
         else if (scanline && slot != 5 && nxt == 0 && old_en == 1) m_irq = 1;
      end
   end

   function automatic int exp_chr(int s);
      int e;
      e = ((m_idx >> 7) & 1) ? (s ^ 4) : s;
      if (e < 4) return (m_bank[e / 2] & 8'hFE) | (e & 1);
      return m_bank[e - 2];
   endfunction

   function automatic int exp_prg(int w);
      bit sw;
      sw = ((m_idx >> 6) & 1) != 0;
      case (w)
         0: return sw ? 8'hFE : m_bank[6];
         1: return m_bank[7];
         2: return sw ? m_bank[6] : 8'hFE;
         default: return 8'hFF;
      endcase
   endfunction

   // compare every output against the reference on each falling edge
   always @(negedge clk) begin
      if (!done) begin
         for (int k = 0; k < 8; k++) check("R3 bank_regs", int'(bank_regs[k*8 +: 8]), m_bank[k]);
         check("R2 index_reg", int'(index_reg), m_idx);
         check("R2 prg_swap", int'(prg_swap), (m_idx >> 6) & 1);
         check("R2 chr_swap", int'(chr_swap), (m_idx >> 7) & 1);
         check("R4 mirror", int'(mirror), m_mirr ^ 1);
         check("R4 ram_ctrl", int'(ram_ctrl), m_ram);
         check("R6 irq", int'(irq), m_irq);
         for (int s = 0; s < 8; s++) check("R8 chr_bank", int'(chr_bank[s*8 +: 8]), exp_chr(s));
         for (int w = 0; w < 4; w++) check("R9 prg_bank", int'(prg_bank[w*8 +: 8]), exp_prg(w));
      end
   end

   // one cycle of stimulus: optional write plus optional scanline
   task automatic cyc(input bit we, input int slot, input int data, input bit sl);
      @(negedge clk);
      wr_en      = we;
      wr_addr_hi = {1'b1, 2'(slot >> 1)};
      wr_a0      = 1'(slot & 1);
      wr_data    = 8'(data);
      scanline   = sl;
      @(negedge clk);
      wr_en    = 1'b0;
      scanline = 1'b0;
   endtask

   task automatic wr(input int slot, input int data);
      cyc(1'b1, slot, data, 1'b0);
   endtask

   task automatic line();
      cyc(1'b0, 0, 0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 irq after reset", int'(irq), 0);
      check("R11 mirror after reset", int'(mirror), 1);
      check("R11 index after reset", int'(index_reg), 0);
      check("R11 prg window 3", int'(prg_bank[31:24]), 8'hFF);
      rst_n = 1'b1;

      // R1: writes with A15 low are ignored
      @(negedge clk);
      wr_en = 1'b1; wr_addr_hi = 3'b000; wr_a0 = 1'b0; wr_data = 8'hC3;
      @(negedge clk);
      wr_addr_hi = 3'b011; wr_a0 = 1'b1; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 1'b0;
      check("R1 index untouched", int'(index_reg), 0);
      check("R1 bank0 untouched", int'(bank_regs[7:0]), 0);
      check("R1 ram untouched", int'(ram_ctrl), 0);

      // R3: fill all eight bank registers
      for (int k = 0; k < 8; k++) begin
         wr(0, k);
         wr(1, 8'h21 + 8'h13 * k);
         check("R3 bank written", int'(bank_regs[k*8 +: 8]), (8'h21 + 8'h13 * k) & 255);
      end

      // R2/R8/R9: all swap combinations
      for (int m = 0; m < 4; m++) begin
         wr(0, (m << 6) | 3);
         check("R2 prg_swap", int'(prg_swap), m & 1);
         check("R2 chr_swap", int'(chr_swap), (m >> 1) & 1);
      end
      wr(0, 8'h80);
      check("R8 swapped slot 0 is bank 2", int'(chr_bank[7:0]), 8'h47);
      check("R8 swapped slot 5 forced odd", int'(chr_bank[47:40]), 8'h21 | 1);
      wr(0, 8'h40);
      check("R9 swapped window 0", int'(prg_bank[7:0]), 8'hFE);
      check("R9 swapped window 2", int'(prg_bank[23:16]), (8'h21 + 8'h13 * 6) & 255);
      wr(0, 8'h00);
      check("R8 slot 0 forced even", int'(chr_bank[7:0]), 8'h20);

      // R4
      wr(2, 8'h01);
      check("R4 mirror from bit0=1", int'(mirror), 0);
      wr(2, 8'hFE);
      check("R4 mirror from bit0=0", int'(mirror), 1);
      wr(3, 8'hA5);
      check("R4 ram byte", int'(ram_ctrl), 8'hA5);

      // R5/R6/R7: reload 3, count four lines
      wr(4, 3); wr(5, 0); wr(7, 0);
      line(); line(); line();
      check("R6 no irq before zero", int'(irq), 0);
      line();
      check("R6 irq on reaching zero", int'(irq), 1);
      line(); line();
      check("R7 irq held over lines", int'(irq), 1);
      wr(6, 0);
      check("R7 ack drops irq", int'(irq), 0);
      wr(7, 0);

      // R5: clear mid-count restarts from reload
      wr(4, 2); wr(5, 0);
      line(); line();
      wr(5, 0);
      line(); line();
      check("R5 clear restarted count", int'(irq), 0);
      line();
      check("R5 irq after restart", int'(irq), 1);
      wr(6, 0); wr(7, 0);

      // R10: clear coincident with a line that would fire
      wr(4, 1); wr(5, 0);
      line();
      cyc(1'b1, 5, 0, 1'b1);
      check("R10 clear beats line", int'(irq), 0);
      line();
      check("R10 reload after clear", int'(irq), 0);
      cyc(1'b1, 6, 0, 1'b1);
      check("R10 ack beats firing line", int'(irq), 0);
      wr(7, 0);
      line();
      cyc(1'b1, 4, 9, 1'b1);
      check("R10 line uses old reload", int'(irq), 1);
      wr(6, 0);

      // R6: reload of zero fires on every line
      wr(4, 0); wr(5, 0); wr(7, 0);
      line();
      check("R6 zero reload fires", int'(irq), 1);
      wr(6, 0); wr(7, 0);
      line();
      check("R6 zero reload fires again", int'(irq), 1);
      wr(6, 0);

      // R10: enable coincident with firing line uses old enable
      wr(4, 0); wr(5, 0);
      cyc(1'b1, 7, 0, 1'b1);
      check("R10 line uses old enable", int'(irq), 0);
      wr(6, 0);

      // mixed traffic, checked by the reference every cycle
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr_en      = ($urandom % 3) == 0;
         wr_addr_hi = 3'(($urandom % 8 == 0) ? ($urandom & 3) : (4 | ($urandom & 3)));
         wr_a0      = 1'($urandom);
         wr_data    = 8'(($urandom % 4 == 0) ? ($urandom % 3) : $urandom);
         scanline   = ($urandom % 3) == 0;
      end
      @(negedge clk);
      wr_en = 1'b0; scanline = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule